// File: doc/BRIEF.md
# Byte-Buffered 16-bit Timer/Event Counter

This block is a 16-bit up-counter with a 16-bit preload register. It is reached from an 8-bit register bus with three addresses: a low byte, a high byte and a control byte. The counter runs in one of three modes. In event mode it counts a selected edge of an external pin. In timer mode it counts cycles in which an internal tick enable is high. In pulse-width mode it measures, once, how many ticks the pin stays at one level. When the counter wraps from all ones, it reloads from the preload register and raises a sticky interrupt flag.

Sixteen-bit values cross the 8-bit bus atomically through one low-byte holding buffer. Software loads a value by writing the low byte first and then the high byte. The high-byte write moves both bytes into the preload register together. Software reads a value by reading the high byte first. That read also copies the counter's low byte into the buffer, and a later low-byte read returns the copy.

The external pin is synchronized inside the block before edge detection. The tick enable is a single-cycle qualifier from a prescaler outside the block.

Top module: `pulse_evt_timer`

## Requirements
- R1: After reset, the counter, the preload, the low buffer, the control byte and the interrupt flag are all zero.
- R2: A bus write to address 0 stores the data only in the low buffer. A write to address 1 loads {data, low buffer} into the preload. When the ON bit is 0, that write also loads the same value into the counter.
- R3: A write to address 1 while ON is 1 leaves the counter value unchanged.
- R4: A read of address 1 returns counter[15:8] and, in the same cycle, copies counter[7:0] into the low buffer. A read of address 0 returns the low buffer. A read of address 2 returns the control byte: bits [1:0] mode, bit 2 ON, bit 3 edge select.
- R5: In timer mode (mode 2'b10) with ON=1, the counter increments by one in each clock cycle in which tick is high.
- R6: When the counter increments from 16'hFFFF, it reloads from the preload register instead and sets the interrupt flag.
- R7: The interrupt flag stays set until an irq_clr pulse clears it. If the flag is set and cleared in the same cycle, it ends up set.
- R8: In event mode (mode 2'b01) with ON=1, each rising edge of the pin increments the counter when edge select is 1, and each falling edge does when it is 0. The pin passes through a two-flop synchronizer first.
- R9: In pulse-width mode (mode 2'b11) with ON=1, the selected pin edge starts a measurement. The counter then increments on each tick while the pin stays at the new level. When the pin returns to its original level, the ON bit clears itself. For a pin pulse K cycles long with tick held high, the count grows by K-1.
- R10: After a measurement ends, further pin edges leave the count unchanged until software sets ON again.
- R11: In mode 2'b00 the counter never increments, whatever the tick and pin do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 2 | Register address: 0 low, 1 high, 2 control |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data |
| ev_pin | input | 1 | External event and measurement pin, asynchronous |
| tick | input | 1 | Internal tick enable |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| irq_flag | output | 1 | Sticky overflow interrupt flag |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, which gives a 16-bit counter, and a two-stage synchronizer. It reaches the wrap at 16'hFFFF in a few ticks by preloading values just below the top. With the fixed two-stage synchronizer, the one-tick shortfall of a measured pulse comes out as an exact count. The bench uses these to check reload, the set-over-clear priority and the one-shot end of a measurement.

// File: rtl/pulse_evt_timer.sv
module pulse_evt_timer #(
  parameter int BUS_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic             ev_pin,
  input  logic             tick,
  input  logic             irq_clr,
  output logic             irq_flag
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2;
  localparam logic [1:0] M_EVT = 2'b01, M_TMR = 2'b10, M_PW = 2'b11;

  logic [CNT_W-1:0] cnt, preload;
  logic [BUS_W-1:0] lo_buf;
  logic [1:0]       mode;
  logic             on, edge_sel, meas;
  logic [SYNC_N:0]  sync_q;

  wire pin_now  = sync_q[SYNC_N-1];
  wire pin_prev = sync_q[SYNC_N];
  wire act_edge = edge_sel ? (pin_now & ~pin_prev) : (~pin_now & pin_prev);

  wire wr_lo  = wr_en && addr == A_LO;
  wire wr_hi  = wr_en && addr == A_HI;
  wire wr_ctl = wr_en && addr == A_CTL;
  wire rd_hi  = rd_en && !wr_en && addr == A_HI;

  wire pw_start = on && mode == M_PW && !meas && act_edge;
  wire pw_end   = meas && (pin_now != edge_sel);
  wire inc      = on && ((mode == M_EVT && act_edge) ||
                         (mode == M_TMR && tick) ||
                         (meas && !pw_end && tick));
  wire wrap     = inc && (&cnt);

  always_comb begin
    case (addr)
      A_LO:    rdata = lo_buf;
      A_HI:    rdata = cnt[CNT_W-1:BUS_W];
      A_CTL:   rdata = BUS_W'({edge_sel, on, mode});
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], ev_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; on <= 1'b0; edge_sel <= 1'b0; meas <= 1'b0;
    end else begin
      if (wr_ctl) {edge_sel, on, mode} <= wdata[3:0];
      else if (pw_end) on <= 1'b0;
      if (wr_ctl || pw_end) meas <= 1'b0;
      else if (pw_start)    meas <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; preload <= '0; lo_buf <= '0; irq_flag <= 1'b0;
    end else begin
      if (wr_hi) preload <= {wdata, lo_buf};
      if (wr_lo)      lo_buf <= wdata;
      else if (rd_hi) lo_buf <= cnt[BUS_W-1:0];
      if (wrap)               cnt <= preload;
      else if (inc)           cnt <= cnt + 1'b1;
      else if (wr_hi && !on)  cnt <= {wdata, lo_buf};
      if (wrap)         irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_evt_timer_chk.sv
module pulse_evt_timer_chk #(
  parameter int BUS_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         addr,
  input logic               irq_clr,
  input logic               irq_flag,
  input logic               inc,
  input logic               on,
  input logic [1:0]         mode,
  input logic [2*BUS_W-1:0] cnt,
  input logic [2*BUS_W-1:0] preload
);
  assert_reload_on_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc && (&cnt) |=> cnt == $past(preload) && irq_flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  assert_hi_write_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd1 && on && !inc |=> $stable(cnt));

  assert_self_clear_pulse_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(on) && !$past(wr_en && addr == 2'd2) |-> mode == 2'b11);

  assert_stopped_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 && !(wr_en && addr == 2'd1) |=> $stable(cnt));
endmodule

bind pulse_evt_timer pulse_evt_timer_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq_clr(irq_clr),
  .irq_flag(irq_flag), .inc(inc), .on(on), .mode(mode), .cnt(cnt), .preload(preload)
);

// File: tb/pulse_evt_timer_test.sv
module pulse_evt_timer_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, ev_pin = 0, tick = 0, irq_clr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       irq_flag;
  int tests = 0, fails = 0;

  pulse_evt_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ev_pin(ev_pin), .tick(tick),
    .irq_clr(irq_clr), .irq_flag(irq_flag));

  always #10 clk = ~clk;

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    rd(2'd1, h); rd(2'd0, l); v = {h, l};
  endtask

  task automatic load(logic [15:0] v);
    wr(2'd2, 8'h00); wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 flag", 16'(irq_flag), 16'h0);
    rd(2'd2, d); chk("R1 ctrl", 16'(d), 16'h0);
    rd(2'd1, d); chk("R1 cnt hi", 16'(d), 16'h0);
    rd(2'd0, d); chk("R1 cnt lo", 16'(d), 16'h0);
  endtask

  task automatic t_access;
    logic [15:0] v;
    logic [7:0] d;
    wr(2'd0, 8'h5A); rd(2'd0, d); chk("R2 low buffer", 16'(d), 16'h5A);
    wr(2'd1, 8'hC3); rd16(v); chk("R2 load while off", v, 16'hC35A);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    load(16'h0000); wr(2'd2, 8'h06);
    @(negedge clk); tick = 1; wait_cyc(5); tick = 0;
    rd16(v); chk("R5 five ticks", v, 16'h0005);
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    rd16(v); chk("R3 count kept while on", v, 16'h0005);
    rd(2'd1, v[15:8]);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    rd(2'd0, v[7:0]); chk("R4 buffered low", 16'(v[7:0]), 16'h05);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    load(16'hFFFD); wr(2'd2, 8'h06);
    @(negedge clk); tick = 1; wait_cyc(3); tick = 0;
    rd16(v); chk("R6 reload", v, 16'hFFFD);
    chk("R6 flag set", 16'(irq_flag), 16'h1);
    wait_cyc(3); chk("R7 sticky", 16'(irq_flag), 16'h1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk("R7 cleared", 16'(irq_flag), 16'h0);
    load(16'hFFFF); wr(2'd2, 8'h06);
    @(negedge clk); tick = 1; irq_clr = 1; @(negedge clk); tick = 0; irq_clr = 0;
    chk("R7 set wins", 16'(irq_flag), 16'h1);
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic pin_pulse(int hi, int lo);
    @(negedge clk); ev_pin = 1; wait_cyc(hi); ev_pin = 0; wait_cyc(lo);
  endtask

  task automatic t_event;
    logic [15:0] v;
    load(16'h0000); wr(2'd2, 8'h0D);
    for (int i = 0; i < 3; i++) pin_pulse(3, 3);
    wait_cyc(4); rd16(v); chk("R8 rising edges", v, 16'h0003);
    wr(2'd2, 8'h05);
    for (int i = 0; i < 2; i++) pin_pulse(3, 3);
    wait_cyc(4); rd16(v); chk("R8 falling edges", v, 16'h0005);
  endtask

  task automatic t_stopped;
    logic [15:0] v;
    load(16'h0042); wr(2'd2, 8'h04);
    @(negedge clk); tick = 1; pin_pulse(3, 3); pin_pulse(3, 3); tick = 0;
    rd16(v); chk("R11 mode 00 holds", v, 16'h0042);
  endtask

  task automatic t_pulse;
    logic [15:0] v;
    logic [7:0] d;
    load(16'h0000); wr(2'd2, 8'h0F);
    @(negedge clk); tick = 1;
    pin_pulse(10, 6);
    rd16(v); chk("R9 width K-1", v, 16'h0009);
    rd(2'd2, d); chk("R9 ON cleared", 16'(d), 16'h0B);
    pin_pulse(10, 6); tick = 0;
    rd16(v); chk("R10 one shot held", v, 16'h0009);
  endtask

  initial begin
    wait_cyc(3); rst_n = 1;
    t_reset; t_access; t_timer; t_overflow; t_event; t_stopped; t_pulse;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule